// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block takes one 64-bit segment descriptor together with a memory access (a 32-bit offset, a length, a kind of access and the current privilege level). It decodes the base, the limit and the attribute bits from the descriptor and forms the linear address as base plus offset. It also decides whether the access is legal. If the access is illegal, it raises a fault and reports one cause code.

The result is registered. A request presented with `in_valid` high returns exactly one cycle later with `out_valid` high. Requests may be issued back to back, one per cycle. Finding the descriptor in a table, loading it into a segment register and handling gate descriptors are left to the surrounding logic.

Access kinds on `in_acc`: 0 = read, 1 = write, 2 = instruction fetch, 3 = illegal kind. Cause codes on `out_cause`: 0 = none, 1 = not present, 2 = type, 3 = privilege, 4 = limit.

Top module: `seg_access_check`

## Requirements
- R1: After reset `out_valid` is 0. In every later cycle, `out_valid` equals the value `in_valid` had one cycle before.
- R2: `out_lin_addr` equals base + offset modulo 2^32. The base is assembled as follows: base[15:0] from descriptor bits 31:16, base[23:16] from bits 39:32, and base[31:24] from bits 63:56.
- R3: The raw 20-bit limit is built from descriptor bits 15:0 (low part) and bits 51:48 (high part). When bit 55 is 0, the effective limit equals the raw limit. When bit 55 is 1, the effective limit is (raw << 12) | 0xFFF.
- R4: A segment that is not expand-down is within bounds when offset + length − 1 does not carry past 2^32 − 1 and is at or below the effective limit. Otherwise the cause is 4.
- R5: A data segment (bit 43 = 0) with bit 42 = 1 is expand-down. It is within bounds only when the offset is above the effective limit and offset + length − 1 is at or below the upper bound. The upper bound is 0xFFFFFFFF when bit 54 is 1 and 0xFFFF when bit 54 is 0. Otherwise the cause is 4.
- R6: A descriptor whose present bit (bit 47) is 0 gives cause 1.
- R7: A type fault (cause 2) occurs in any of these cases:
  - bit 44 is 0 (system descriptor);
  - the access is a write to a code segment (bit 43 = 1);
  - the access is a write to a data segment with bit 41 = 0;
  - the access is a read of a code segment with bit 41 = 0;
  - the access is a fetch from a data segment;
  - the access kind is 3.
- R8: For a data segment, a current privilege level numerically greater than the descriptor privilege level (bits 46:45) gives cause 3. Code segments undergo no privilege test.
- R9: When several faults apply at once, only the highest-priority one is reported. The order is not-present, then type, then privilege, then limit. `out_fault` is 1 exactly when the cause is not 0.
- R10: In a cycle after `in_valid` was low, `out_lin_addr`, `out_fault` and `out_cause` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_desc | input | 64 | Segment descriptor |
| in_offset | input | 32 | Offset within the segment |
| in_len_m1 | input | LEN_W | Access length in bytes minus one |
| in_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 illegal |
| in_cpl | input | 2 | Current privilege level |
| out_valid | output | 1 | Result valid |
| out_lin_addr | output | 32 | Linear address |
| out_fault | output | 1 | Access refused |
| out_cause | output | 3 | Cause code, 0 when there is no fault |

## Verification
A single request can fail the present, type, privilege and bound tests all in the same cycle, and the encoder has to pick one cause. The bench provokes these collisions with a full sweep over:
- the present, system, type and privilege bits;
- the privilege level;
- the access kind.

In this sweep the descriptor is deliberately shaped so that some of its layouts also break the bound. A second sweep moves offsets and lengths across the edge of the effective limit, for both granularities, both expansion directions and both upper bounds. Each returned cause is judged against a priority-ordered reference model computed arithmetically in the bench.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

   localparam int DESC_W = 64;
   localparam int ADDR_W = 32;
   localparam int RAW_LIM_W = 20;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_ABSENT  = 3'd1,
      CAUSE_TYPE    = 3'd2,
      CAUSE_PRIV    = 3'd3,
      CAUSE_BOUND   = 3'd4
   } cause_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_BAD   = 2'd3
   } acc_e;

   typedef struct packed {
      logic [ADDR_W-1:0] base;
      logic [ADDR_W-1:0] lim_eff;
      logic              present;
      logic [1:0]        dpl;
      logic              app;       // 1: code/data, 0: system
      logic              exec;      // code segment
      logic              conf_dn;   // conforming (code) / expand-down (data)
      logic              rw;        // readable (code) / writable (data)
      logic              big;       // upper bound selector for expand-down
   } seg_fields_t;

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
   import seg_chk_pkg::*;
#(
   parameter int GRAN_SHIFT = 12
) (
   input  logic [DESC_W-1:0] desc,
   output seg_fields_t       fields
);

   localparam int SCALED_W = RAW_LIM_W + GRAN_SHIFT;

   if (GRAN_SHIFT < 0 || SCALED_W > ADDR_W) begin : g_bad_shift
      $error("seg_desc_decode: GRAN_SHIFT out of range");
   end

   logic [RAW_LIM_W-1:0] lim_raw;
   logic [ADDR_W-1:0]    lim_coarse;
   logic                 gran;
   logic                 unused_bits;

   assign lim_raw = {desc[51:48], desc[15:0]};
   assign gran    = desc[55];
   assign unused_bits = ^{desc[40], desc[53:52]};

   if (GRAN_SHIFT == 0) begin : g_flat
      assign lim_coarse = {{(ADDR_W-RAW_LIM_W){1'b0}}, lim_raw};
   end else begin : g_scaled
      logic [ADDR_W-1:0] lim_ext;
      logic [ADDR_W-1:0] fill;
      assign lim_ext    = {{(ADDR_W-RAW_LIM_W){1'b0}}, lim_raw};
      assign fill       = (ADDR_W'(1) << GRAN_SHIFT) - ADDR_W'(1);
      assign lim_coarse = (lim_ext << GRAN_SHIFT) | fill;
   end

   always_comb begin
      fields.base    = {desc[63:56], desc[39:32], desc[31:16]};
      fields.lim_eff = gran ? lim_coarse
                            : {{(ADDR_W-RAW_LIM_W){1'b0}}, lim_raw};
      fields.present = desc[47];
      fields.dpl     = desc[46:45];
      fields.app     = desc[44];
      fields.exec    = desc[43];
      fields.conf_dn = desc[42];
      fields.rw      = desc[41];
      fields.big     = desc[54];
   end

endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
   import seg_chk_pkg::*;
#(
   parameter int CPL_W = 2
) (
   input  seg_fields_t      fields,
   input  logic [1:0]       acc,
   input  logic [CPL_W-1:0] cpl,
   output logic             type_bad,
   output logic             priv_bad
);

   if (CPL_W != 2) begin : g_bad_cpl
      $error("seg_rights_check: privilege field must be two bits wide");
   end

   acc_e kind;
   logic code_bad;
   logic data_bad;

   assign kind = acc_e'(acc);

   always_comb begin
      code_bad = 1'b0;
      data_bad = 1'b0;
      unique case (kind)
         ACC_READ:  begin code_bad = !fields.rw; data_bad = 1'b0;       end
         ACC_WRITE: begin code_bad = 1'b1;       data_bad = !fields.rw; end
         ACC_FETCH: begin code_bad = 1'b0;       data_bad = 1'b1;       end
         default:   begin code_bad = 1'b1;       data_bad = 1'b1;       end
      endcase
   end

   assign type_bad = !fields.app || (fields.exec ? code_bad : data_bad);
   assign priv_bad = !fields.exec && (cpl > fields.dpl);

endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check
   import seg_chk_pkg::*;
#(
   parameter int LEN_W = 4,
   parameter int SMALL_TOP = 16'hFFFF
) (
   input  seg_fields_t       fields,
   input  logic [ADDR_W-1:0] offset,
   input  logic [LEN_W-1:0]  len_m1,
   output logic              bound_bad
);

   if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
      $error("seg_bound_check: LEN_W must lie in 1..8");
   end

   localparam int SUM_W = ADDR_W + 1;

   logic [SUM_W-1:0] last_byte;
   logic [SUM_W-1:0] lim_wide;
   logic [SUM_W-1:0] top_wide;
   logic             expand_dn;
   logic             up_ok;
   logic             dn_ok;

   assign last_byte = {1'b0, offset} + SUM_W'(len_m1);
   assign lim_wide  = {1'b0, fields.lim_eff};
   assign top_wide  = fields.big ? {1'b0, {ADDR_W{1'b1}}} : SUM_W'(SMALL_TOP);
   assign expand_dn = !fields.exec && fields.conf_dn;

   assign up_ok = (last_byte <= lim_wide);
   assign dn_ok = ({1'b0, offset} > lim_wide) && (last_byte <= top_wide);

   assign bound_bad = expand_dn ? !dn_ok : !up_ok;

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
   import seg_chk_pkg::*;
#(
   parameter int LEN_W = 4,
   parameter int GRAN_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [63:0]       in_desc,
   input  logic [31:0]       in_offset,
   input  logic [LEN_W-1:0]  in_len_m1,
   input  logic [1:0]        in_acc,
   input  logic [1:0]        in_cpl,
   output logic              out_valid,
   output logic [31:0]       out_lin_addr,
   output logic              out_fault,
   output logic [2:0]        out_cause
);

   seg_fields_t fields;
   logic        type_bad;
   logic        priv_bad;
   logic        bound_bad;
   cause_e      cause_nx;
   logic        fault_nx;

   seg_desc_decode #(.GRAN_SHIFT(GRAN_SHIFT)) u_decode (
      .desc   (in_desc),
      .fields (fields)
   );

   seg_rights_check #(.CPL_W(2)) u_rights (
      .fields   (fields),
      .acc      (in_acc),
      .cpl      (in_cpl),
      .type_bad (type_bad),
      .priv_bad (priv_bad)
   );

   seg_bound_check #(.LEN_W(LEN_W)) u_bound (
      .fields    (fields),
      .offset    (in_offset),
      .len_m1    (in_len_m1),
      .bound_bad (bound_bad)
   );

   always_comb begin
      if (!fields.present)  cause_nx = CAUSE_ABSENT;
      else if (type_bad)    cause_nx = CAUSE_TYPE;
      else if (priv_bad)    cause_nx = CAUSE_PRIV;
      else if (bound_bad)   cause_nx = CAUSE_BOUND;
      else                  cause_nx = CAUSE_NONE;
   end

   assign fault_nx = !fields.present || type_bad || priv_bad || bound_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_lin_addr <= '0;
         out_fault    <= 1'b0;
         out_cause    <= CAUSE_NONE;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_lin_addr <= fields.base + in_offset;
            out_fault    <= fault_nx;
            out_cause    <= cause_nx;
         end
      end
   end

endmodule

// File: rtl/seg_access_check_props.sv
module seg_access_check_props (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [63:0] in_desc,
   input logic [31:0] in_offset,
   input logic        out_valid,
   input logic [31:0] out_lin_addr,
   input logic        out_fault,
   input logic [2:0]  out_cause
);

   logic [31:0] base_chk;
   assign base_chk = {in_desc[63:56], in_desc[39:32], in_desc[31:16]};

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_lin_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_lin_addr == $past(base_chk + in_offset));

   assert_absent_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_desc[47]) |=> out_cause == 3'd1);

   assert_system_type_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_desc[47] && !in_desc[44]) |=> out_cause == 3'd2);

   assert_fault_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_fault == (out_cause != 3'd0)));

   assert_cause_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_cause <= 3'd4);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_lin_addr) && $stable(out_cause) && $stable(out_fault)));

endmodule

bind seg_access_check seg_access_check_props u_props (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_desc      (in_desc),
   .in_offset    (in_offset),
   .out_valid    (out_valid),
   .out_lin_addr (out_lin_addr),
   .out_fault    (out_fault),
   .out_cause    (out_cause)
);

// File: tb/seg_access_check_test.sv
module seg_access_check_test;

   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [63:0]   in_desc = '0;
   logic [31:0]   in_offset = '0;
   logic [LW-1:0] in_len_m1 = '0;
   logic [1:0]    in_acc = '0;
   logic [1:0]    in_cpl = '0;
   logic          out_valid;
   logic [31:0]   out_lin_addr;
   logic          out_fault;
   logic [2:0]    out_cause;

   int n_checks = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   seg_access_check #(.LEN_W(LW), .GRAN_SHIFT(12)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_desc      (in_desc),
      .in_offset    (in_offset),
      .in_len_m1    (in_len_m1),
      .in_acc       (in_acc),
      .in_cpl       (in_cpl),
      .out_valid    (out_valid),
      .out_lin_addr (out_lin_addr),
      .out_fault    (out_fault),
      .out_cause    (out_cause)
   );

   function automatic logic [63:0] make_desc(
      input logic [31:0] base, input logic [19:0] lim, input logic g,
      input logic d, input logic p, input logic [1:0] dpl, input logic s,
      input logic [2:0] typ);
      logic [63:0] r;
      r = '0;
      r[15:0]  = lim[15:0];
      r[31:16] = base[15:0];
      r[39:32] = base[23:16];
      r[43:41] = typ;
      r[44]    = s;
      r[46:45] = dpl;
      r[47]    = p;
      r[51:48] = lim[19:16];
      r[54]    = d;
      r[55]    = g;
      r[63:56] = base[31:24];
      return r;
   endfunction

   function automatic logic [2:0] ref_cause(
      input logic [63:0] dsc, input logic [31:0] off, input logic [LW-1:0] lm1,
      input logic [1:0] acc, input logic [1:0] cpl);
      longint unsigned lim, last, top;
      logic code, bad_type, bad_priv, bad_lim;
      lim = {dsc[51:48], dsc[15:0]};
      if (dsc[55]) lim = lim * 4096 + 4095;
      code = dsc[43];
      last = longint'(off) + longint'(lm1);
      bad_type = !dsc[44] || acc == 2'd3
              || (acc == 2'd1 && (code || !dsc[41]))
              || (acc == 2'd0 && code && !dsc[41])
              || (acc == 2'd2 && !code);
      bad_priv = !code && (cpl > dsc[46:45]);
      if (!code && dsc[42]) begin
         top = dsc[54] ? 64'hFFFF_FFFF : 64'hFFFF;
         bad_lim = !(longint'(off) > lim && last <= top);
      end else begin
         bad_lim = !(last <= lim);
      end
      if (!dsc[47]) return 3'd1;
      if (bad_type) return 3'd2;
      if (bad_priv) return 3'd3;
      if (bad_lim)  return 3'd4;
      return 3'd0;
   endfunction

   function automatic string tag_of(input logic [2:0] c, input logic [63:0] dsc);
      case (c)
         3'd1: return "R6/R9";
         3'd2: return "R7/R9";
         3'd3: return "R8/R9";
         3'd4: return (!dsc[43] && dsc[42]) ? "R5/R3" : "R4/R3";
         default: return "R4 R5 R7 R8 pass";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, sample result at the following negedge
   task automatic run_vec(input logic [63:0] dsc, input logic [31:0] off,
                          input logic [LW-1:0] lm1, input logic [1:0] acc,
                          input logic [1:0] cpl);
      logic [2:0]  ec;
      logic [31:0] ea;
      in_valid = 1'b1; in_desc = dsc; in_offset = off;
      in_len_m1 = lm1; in_acc = acc; in_cpl = cpl;
      ec = ref_cause(dsc, off, lm1, acc, cpl);
      ea = {dsc[63:56], dsc[39:32], dsc[31:16]} + off;
      @(negedge clk);
      check("R1 valid", 32'(out_valid), 32'd1);
      check({tag_of(ec, dsc), " cause"}, 32'(out_cause), 32'(ec));
      check("R9 fault flag", 32'(out_fault), 32'(ec != 3'd0));
      check("R2 linear address", out_lin_addr, ea);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      logic [31:0] prev_addr;
      logic [2:0]  prev_cause;
      repeat (3) @(negedge clk);
      check("R1 reset valid", 32'(out_valid), 32'd0);
      check("R1 reset cause", 32'(out_cause), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", 32'(out_valid), 32'd0);

      // attribute sweep: present, system, type, dpl, cpl, access kind
      for (int p = 0; p < 2; p++)
         for (int s = 0; s < 2; s++)
            for (int t = 0; t < 8; t++)
               for (int dp = 0; dp < 4; dp++)
                  for (int cp = 0; cp < 4; cp++)
                     for (int a = 0; a < 4; a++) begin
                        logic [31:0] b;
                        b = 32'h0101_0101 * 32'(t + 8 * dp) + 32'h00F0_0000;
                        run_vec(make_desc(b, 20'h00100, 1'b0, 1'b1, p[0], dp[1:0],
                                          s[0], t[2:0]),
                                32'h0000_00F0 + 32'(a * 4), LW'(a * 5), a[1:0], cp[1:0]);
                     end

      // bound sweep: granularity, direction, upper bound, limits, offsets, lengths
      for (int g = 0; g < 2; g++)
         for (int e = 0; e < 2; e++)
            for (int d = 0; d < 2; d++)
               for (int li = 0; li < 5; li++)
                  for (int oi = 0; oi < 9; oi++)
                     for (int ln = 0; ln < 4; ln++) begin
                        logic [19:0] lr;
                        logic [31:0] eff, off;
                        case (li)
                           0: lr = 20'h00000;
                           1: lr = 20'h00001;
                           2: lr = 20'h0FFFF;
                           3: lr = 20'hFFFFF;
                           default: lr = 20'h12345;
                        endcase
                        eff = g ? {lr, 12'hFFF} : {12'h000, lr};
                        case (oi)
                           0: off = eff - 32'd2;
                           1: off = eff - 32'd1;
                           2: off = eff;
                           3: off = eff + 32'd1;
                           4: off = eff + 32'd2;
                           5: off = 32'h0;
                           6: off = 32'h0000_FFFE;
                           7: off = 32'hFFFF_FFFE;
                           default: off = 32'hFFFF_FFFF;
                        endcase
                        run_vec(make_desc(32'h1234_5000, lr, g[0], d[0], 1'b1, 2'd3,
                                          1'b1, {1'b0, e[0], 1'b1}),
                                off, LW'(ln), 2'd0, 2'd0);
                     end

      // R10: idle cycle with altered inputs leaves results untouched
      prev_addr = out_lin_addr;
      prev_cause = out_cause;
      in_valid = 1'b0;
      in_desc = make_desc(32'hDEAD_0000, 20'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0);
      in_offset = 32'h0BAD_0000;
      @(negedge clk);
      check("R1 valid drops", 32'(out_valid), 32'd0);
      check("R10 address held", out_lin_addr, prev_addr);
      check("R10 cause held", 32'(out_cause), 32'(prev_cause));
      @(negedge clk);
      check("R10 address held twice", out_lin_addr, prev_addr);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule